// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Write-Back Cache

This block is a direct-mapped data cache placed between a processor port and a slower memory. Each line has one tag and is divided into sub-blocks. Every sub-block has its own valid bit and its own dirty bit. Memory traffic therefore moves one sub-block at a time. A miss fetches only the sub-block it needs. Evicting a line writes back only the sub-blocks that were modified.

Stores follow a write-back, write-allocate policy. A store hit changes only the cache copy. A store miss first brings the sub-block in and then merges the store word into it. The processor port takes one word request at a time when `ready_o` is high and acknowledges it with a one-cycle `rvalid_o` pulse.

The memory port moves a sub-block as eight 32-bit beats. It holds a request with a fixed base address and counts acknowledges. With the default parameters there are 4 lines of 4 sub-blocks, each sub-block holding 8 words.

Top module: `sbc_cache`

## Requirements
- R1: After reset every sub-block is invalid and clean, `ready_o` is 1, and both `rvalid_o` and `mem_req_o` are 0.
- R2: The address splits as follows: bits [1:0] are the byte offset and are ignored, bits [4:2] select the word, bits [6:5] select the sub-block, bits [8:7] select the line (default of 4 lines), and the bits above form the tag. Lines with different indices are held independently.
- R3: A read hit returns `rdata_o` with `rvalid_o` in the cycle after the request is accepted and causes no memory traffic.
- R4: A write hit updates only the cache and marks its sub-block dirty. It is acknowledged by `rvalid_o` in the next cycle and causes no memory traffic.
- R5: When the tag matches and the requested sub-block is invalid, exactly one read burst is issued, for that sub-block only, and nothing is written back.
- R6: A burst drives `mem_addr_o` with the sub-block base address (low 5 bits zero). It holds `mem_req_o`, `mem_addr_o` and `mem_we_o` steady until the eighth `mem_ack_i`. Beat k carries the word at base+4k. `mem_we_o`=1 marks a write-back and 0 marks a fill.
- R7: On a tag mismatch, every valid dirty sub-block of the old line is written back in ascending sub-block order, and clean sub-blocks are not written back. The requested sub-block is then fetched under the new tag, and all other sub-blocks of the line become invalid.
- R8: A write miss fetches the sub-block and then merges the store word. Later reads return the stored word, and the other words of that sub-block come from memory.
- R9: Write-back bursts carry the most recent values stored to those words.
- R10: `ready_o` is 0 from the cycle after a miss is accepted until its response. `rvalid_o` is a single-cycle pulse per request.
- R11: A sub-block is never dirty while invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request, accepted when `ready_o` is 1 |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data |
| ready_o | output | 1 | Cache can accept a request |
| rvalid_o | output | 1 | Request completed (one-cycle pulse) |
| rdata_o | output | 32 | Load data, valid with `rvalid_o` |
| mem_req_o | output | 1 | Memory burst in progress |
| mem_we_o | output | 1 | 1 = write-back burst, 0 = fill burst |
| mem_addr_o | output | 32 | Sub-block base address |
| mem_wdata_o | output | 32 | Write-back beat data |
| mem_ack_i | input | 1 | Memory accepts or delivers one beat |
| mem_rdata_i | input | 32 | Fill beat data |

## Verification
The assertions check several properties on every cycle:
- a sub-block is never dirty while invalid;
- a write-back only ever targets a valid dirty sub-block, and write-backs move to higher sub-blocks only;
- a fill only targets an invalid sub-block of the installed tag;
- a pending burst holds its address and direction;
- a hit answers in the next cycle with no memory request.

Only the bench scenarios can show the rest:
- which bursts a given access produces, and their order;
- that write-backs carry the merged store data;
- that clean sub-blocks are skipped on eviction;
- that a write miss merges into fetched data;
- that separate line indices stay independent.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL, ST_RESP} sbc_state_e;
endpackage

// File: rtl/sbc_tag_store.sv
`timescale 1ns/1ps
module sbc_tag_store #(
  parameter int LINES = 4,
  parameter int SUBS  = 4,
  parameter int TAG_B = 23,
  localparam int IDX_B = $clog2(LINES),
  localparam int SUB_B = $clog2(SUBS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_B-1:0] rd_idx_i,
  output logic [TAG_B-1:0] rd_tag_o,
  output logic [SUBS-1:0]  rd_valid_o,
  output logic [SUBS-1:0]  rd_dirty_o,
  input  logic [IDX_B-1:0] wr_idx_i,
  input  logic [SUB_B-1:0] wr_sub_i,
  input  logic [TAG_B-1:0] wr_tag_i,
  input  logic             install_i,
  input  logic             set_valid_i,
  input  logic             set_dirty_i
);
  logic [TAG_B-1:0] tag_q   [LINES];
  logic [SUBS-1:0]  valid_q [LINES];
  logic [SUBS-1:0]  dirty_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) begin
        tag_q[l]   <= '0;
        valid_q[l] <= '0;
        dirty_q[l] <= '0;
      end
    end else begin
      if (install_i) begin
        tag_q[wr_idx_i]   <= wr_tag_i;
        valid_q[wr_idx_i] <= '0;
        dirty_q[wr_idx_i] <= '0;
      end
      if (set_valid_i) begin
        valid_q[wr_idx_i][wr_sub_i] <= 1'b1;
        dirty_q[wr_idx_i][wr_sub_i] <= 1'b0;
      end
      if (set_dirty_i) dirty_q[wr_idx_i][wr_sub_i] <= 1'b1;
    end
  end

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];

  for (genvar l = 0; l < LINES; l++) begin : g_chk
    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dirty_q[l] & ~valid_q[l]) == '0); // R11
  end
endmodule

// File: rtl/sbc_data_store.sv
`timescale 1ns/1ps
module sbc_data_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sbc_cache.sv
`timescale 1ns/1ps
module sbc_cache
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int SUBS   = 4,
  parameter int WORDS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_B  = $clog2(DATA_W / 8);
  localparam int WORD_B  = $clog2(WORDS);
  localparam int SUB_B   = $clog2(SUBS);
  localparam int IDX_B   = $clog2(LINES);
  localparam int WORD_LO = BYTE_B;
  localparam int SUB_LO  = WORD_LO + WORD_B;
  localparam int IDX_LO  = SUB_LO + SUB_B;
  localparam int TAG_LO  = IDX_LO + IDX_B;
  localparam int TAG_B   = ADDR_W - TAG_LO;
  localparam int DA_W    = IDX_B + SUB_B + WORD_B;

  function automatic logic [SUB_B-1:0] low_idx(input logic [SUBS-1:0] m);
    logic [SUB_B-1:0] r;
    r = '0;
    for (int i = SUBS - 1; i >= 0; i--) if (m[i]) r = SUB_B'(i);
    return r;
  endfunction

  sbc_state_e state_q;
  logic              r_we_q;
  logic [TAG_B-1:0]  r_tag_q;
  logic [IDX_B-1:0]  r_idx_q;
  logic [SUB_B-1:0]  r_sub_q;
  logic [WORD_B-1:0] r_word_q;
  logic [DATA_W-1:0] r_wdata_q;
  logic [WORD_B-1:0] beat_q;
  logic [SUB_B-1:0]  wb_sub_q;
  logic [SUBS-1:0]   wb_mask_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_B-1:0]  a_tag;
  logic [IDX_B-1:0]  a_idx;
  logic [SUB_B-1:0]  a_sub;
  logic [WORD_B-1:0] a_word;
  logic              unused_byte;

  assign a_tag  = addr_i[ADDR_W-1:TAG_LO];
  assign a_idx  = addr_i[TAG_LO-1:IDX_LO];
  assign a_sub  = addr_i[IDX_LO-1:SUB_LO];
  assign a_word = addr_i[SUB_LO-1:WORD_LO];
  assign unused_byte = ^addr_i[BYTE_B-1:0];

  logic              in_idle;
  logic [IDX_B-1:0]  lk_idx;
  logic [TAG_B-1:0]  line_tag;
  logic [SUBS-1:0]   line_valid, line_dirty, dmask, wb_rest;
  logic              accept, hit, tag_miss, last_beat, nxt_any;
  logic              ts_install, ts_set_valid, ts_set_dirty;
  logic [IDX_B-1:0]  ts_idx;
  logic [SUB_B-1:0]  ts_sub;
  logic [TAG_B-1:0]  ts_tag;
  logic              dw_en;
  logic [DA_W-1:0]   dw_addr, dr_addr;
  logic [DATA_W-1:0] dw_data, dr_data;

  assign in_idle   = (state_q == ST_IDLE);
  assign lk_idx    = in_idle ? a_idx : r_idx_q;
  assign accept    = req_i && in_idle;
  assign tag_miss  = (line_tag != a_tag);
  assign hit       = !tag_miss && line_valid[a_sub];
  assign dmask     = line_valid & line_dirty;
  assign last_beat = mem_ack_i && (beat_q == WORD_B'(WORDS - 1));
  assign wb_rest   = wb_mask_q & ~(SUBS'(1) << wb_sub_q);
  assign nxt_any   = |wb_rest;

  // tag store write side: request fields in IDLE, latched fields otherwise
  assign ts_idx       = in_idle ? a_idx : r_idx_q;
  assign ts_sub       = in_idle ? a_sub : r_sub_q;
  assign ts_tag       = in_idle ? a_tag : r_tag_q;
  assign ts_install   = (accept && !hit && tag_miss && (dmask == '0)) ||
                        (state_q == ST_WB && last_beat && !nxt_any);
  assign ts_set_valid = (state_q == ST_FILL) && last_beat;
  assign ts_set_dirty = (accept && hit && we_i) || (state_q == ST_RESP && r_we_q);

  always_comb begin
    dw_en   = 1'b0;
    dw_addr = {a_idx, a_sub, a_word};
    dw_data = wdata_i;
    dr_addr = {a_idx, a_sub, a_word};
    unique case (state_q)
      ST_IDLE: dw_en = accept && hit && we_i;
      ST_WB:   dr_addr = {r_idx_q, wb_sub_q, beat_q};
      ST_FILL: begin
        dw_en   = mem_ack_i;
        dw_addr = {r_idx_q, r_sub_q, beat_q};
        dw_data = mem_rdata_i;
      end
      ST_RESP: begin
        dr_addr = {r_idx_q, r_sub_q, r_word_q};
        dw_en   = r_we_q;
        dw_addr = {r_idx_q, r_sub_q, r_word_q};
        dw_data = r_wdata_q;
      end
      default: ;
    endcase
  end

  sbc_tag_store #(.LINES(LINES), .SUBS(SUBS), .TAG_B(TAG_B)) u_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_tag_o(line_tag), .rd_valid_o(line_valid), .rd_dirty_o(line_dirty),
    .wr_idx_i(ts_idx), .wr_sub_i(ts_sub), .wr_tag_i(ts_tag),
    .install_i(ts_install), .set_valid_i(ts_set_valid), .set_dirty_i(ts_set_dirty)
  );

  sbc_data_store #(.DEPTH(LINES * SUBS * WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i,
    .we_i(dw_en), .waddr_i(dw_addr), .wdata_i(dw_data),
    .raddr_i(dr_addr), .rdata_o(dr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      r_we_q    <= 1'b0;
      r_tag_q   <= '0;
      r_idx_q   <= '0;
      r_sub_q   <= '0;
      r_word_q  <= '0;
      r_wdata_q <= '0;
      beat_q    <= '0;
      wb_sub_q  <= '0;
      wb_mask_q <= '0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          r_we_q    <= we_i;
          r_tag_q   <= a_tag;
          r_idx_q   <= a_idx;
          r_sub_q   <= a_sub;
          r_word_q  <= a_word;
          r_wdata_q <= wdata_i;
          beat_q    <= '0;
          if (hit) begin
            rvalid_q <= 1'b1;
            rdata_q  <= we_i ? wdata_i : dr_data;
          end else if (tag_miss && (dmask != '0)) begin
            wb_mask_q <= dmask;
            wb_sub_q  <= low_idx(dmask);
            state_q   <= ST_WB;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_WB: if (mem_ack_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            if (nxt_any) begin
              wb_mask_q <= wb_rest;
              wb_sub_q  <= low_idx(wb_rest);
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: if (mem_ack_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_RESP;
        end
        ST_RESP: begin
          rvalid_q <= 1'b1;
          rdata_q  <= r_we_q ? r_wdata_q : dr_data;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = in_idle;
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ?
                       {line_tag, r_idx_q, wb_sub_q, {(SUB_LO){1'b0}}} :
                       {r_tag_q,  r_idx_q, r_sub_q,  {(SUB_LO){1'b0}}};
  assign mem_wdata_o = dr_data;

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && hit |=> rvalid_o && ready_o); // R3
  AST_HIT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && hit |=> !mem_req_o); // R4
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R6
  AST_WB_DIRTY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WB |-> line_valid[wb_sub_q] && line_dirty[wb_sub_q]); // R7
  AST_WB_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WB && $past(state_q) == ST_WB && wb_sub_q != $past(wb_sub_q)
      |-> wb_sub_q > $past(wb_sub_q)); // R7
  AST_FILL_INVALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FILL |-> !line_valid[r_sub_q] && line_tag == r_tag_q); // R5
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R10
endmodule

// File: tb/tb_sbc_cache.sv
`timescale 1ns/1ps
module tb_sbc_cache;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        ready_o, rvalid_o, mem_req_o, mem_we_o;
  logic [31:0] rdata_o, mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk = ~clk;

  sbc_cache dut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ready_o, .rvalid_o, .rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] mm     [0:4095];
  logic [31:0] shadow [0:4095];
  logic [31:0] log_addr [0:63];
  logic        log_we   [0:63];
  int log_n = 0;
  int addr_slips = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: one beat every other cycle
  initial begin
    int beat;
    logic [31:0] base;
    beat = 0;
    base = '0;
    forever begin
      @(negedge clk);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (beat == 0) begin
          base = mem_addr_o;
          log_addr[log_n] = mem_addr_o;
          log_we[log_n]   = mem_we_o;
          log_n++;
        end else if (mem_addr_o !== base) addr_slips++;
        if (mem_we_o) mm[((base >> 2) + beat) & 4095] = mem_wdata_o;
        else mem_rdata_i = mm[((base >> 2) + beat) & 4095];
        mem_ack_i = 1'b1;
        beat = (beat + 1) % 8;
      end
    end
  end

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    logic busy;
    @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    lat = 1;
    busy = !ready_o;
    while (!rvalid_o && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata_o;
    if (w) shadow[(a >> 2) & 4095] = d;
    if (lat > 1) chk("R10 ready low during miss", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk("R10 rvalid single pulse", {31'b0, rvalid_o}, 32'd0);
  endtask

  task automatic chk_burst(input string req, input int k, input logic w, input logic [31:0] a);
    chk({req, " burst addr"}, log_addr[k], a);
    chk({req, " burst dir"}, {31'b0, log_we[k]}, {31'b0, w});
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", {31'b0, ready_o}, 32'd1);
    chk("R1 rvalid after reset", {31'b0, rvalid_o}, 32'd0);
    chk("R1 mem_req after reset", {31'b0, mem_req_o}, 32'd0);
  endtask

  task automatic t_cold_fill;
    logic [31:0] rd; int lat, n0;
    n0 = log_n;
    access(1'b0, 32'h44, '0, rd, lat);
    chk("R1 cold access misses", {31'b0, lat > 1}, 32'd1);
    chk("R5 one fill burst", log_n - n0, 1);
    chk_burst("R5", n0, 1'b0, 32'h40);
    chk("R6 fill word data", rd, shadow[32'h44 >> 2]);
    for (int i = 0; i < 8; i++) begin
      access(1'b0, 32'h40 + 4 * i, '0, rd, lat);
      chk("R3 hit latency", lat, 1);
      chk("R6 beat order data", rd, shadow[(32'h40 >> 2) + i]);
    end
    chk("R3 hits no traffic", log_n - n0, 1);
    access(1'b0, 32'h47, '0, rd, lat);
    chk("R2 byte offset ignored", rd, shadow[32'h44 >> 2]);
  endtask

  task automatic t_write_hit;
    logic [31:0] rd; int lat, n0;
    n0 = log_n;
    access(1'b1, 32'h48, 32'h1111_0001, rd, lat);
    chk("R4 write hit ack latency", lat, 1);
    access(1'b0, 32'h48, '0, rd, lat);
    chk("R4 write hit readback", rd, 32'h1111_0001);
    chk("R4 write hit no traffic", log_n - n0, 0);
    chk("R4 memory untouched", mm[32'h48 >> 2], 32'hC0DE_0048);
  endtask

  task automatic t_write_miss;
    logic [31:0] rd; int lat, n0;
    n0 = log_n;
    access(1'b1, 32'h64, 32'h2222_0002, rd, lat);
    chk("R8 write miss one burst", log_n - n0, 1);
    chk_burst("R8", n0, 1'b0, 32'h60);
    access(1'b0, 32'h64, '0, rd, lat);
    chk("R8 merged word", rd, 32'h2222_0002);
    access(1'b0, 32'h68, '0, rd, lat);
    chk("R8 neighbour from memory", rd, 32'hC0DE_0068);
  endtask

  task automatic t_evict_dirty;
    logic [31:0] rd; int lat, n0;
    n0 = log_n;
    access(1'b0, 32'h224, '0, rd, lat);
    chk("R7 evict burst count", log_n - n0, 3);
    chk_burst("R7 first wb", n0, 1'b1, 32'h40);
    chk_burst("R7 second wb", n0 + 1, 1'b1, 32'h60);
    chk_burst("R7 new fill", n0 + 2, 1'b0, 32'h220);
    chk("R9 wb data sub2", mm[32'h48 >> 2], 32'h1111_0001);
    chk("R9 wb data sub3", mm[32'h64 >> 2], 32'h2222_0002);
    chk("R7 fill data", rd, shadow[32'h224 >> 2]);
    n0 = log_n;
    access(1'b0, 32'h248, '0, rd, lat);
    chk("R7 other subs invalid", log_n - n0, 1);
    chk_burst("R7 sub2 fill", n0, 1'b0, 32'h240);
  endtask

  task automatic t_evict_clean;
    logic [31:0] rd; int lat, n0;
    n0 = log_n;
    access(1'b0, 32'h50, '0, rd, lat);
    chk("R7 clean eviction no wb", log_n - n0, 1);
    chk_burst("R7 clean", n0, 1'b0, 32'h40);
    chk("R9 refetched stored value", rd, shadow[32'h50 >> 2]);
    access(1'b0, 32'h48, '0, rd, lat);
    chk("R9 write survives round trip", rd, 32'h1111_0001);
  endtask

  task automatic t_index;
    logic [31:0] rd; int lat, n0;
    n0 = log_n;
    access(1'b0, 32'h84, '0, rd, lat);
    chk("R2 other index fills", log_n - n0, 1);
    chk_burst("R2", n0, 1'b0, 32'h80);
    access(1'b0, 32'h50, '0, rd, lat);
    chk("R2 index 0 still hits", lat, 1);
    chk("R2 index 0 data", rd, shadow[32'h50 >> 2]);
  endtask

  task automatic t_wb_order;
    logic [31:0] rd; int lat, n0;
    access(1'b1, 32'hE0, 32'h3333_0003, rd, lat);
    access(1'b1, 32'h84, 32'h4444_0004, rd, lat);
    chk("R4 hit write in index 1", lat, 1);
    n0 = log_n;
    access(1'b0, 32'h2A0, '0, rd, lat);
    chk("R7 order burst count", log_n - n0, 3);
    chk_burst("R7 ascending first", n0, 1'b1, 32'h80);
    chk_burst("R7 ascending second", n0 + 1, 1'b1, 32'hE0);
    chk_burst("R7 ascending fill", n0 + 2, 1'b0, 32'h2A0);
    chk("R9 wb sub0", mm[32'h84 >> 2], 32'h4444_0004);
    chk("R9 wb sub3", mm[32'hE0 >> 2], 32'h3333_0003);
    chk("R6 address held", addr_slips, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mm[i]     = 32'hC0DE_0000 ^ (i * 4);
      shadow[i] = 32'hC0DE_0000 ^ (i * 4);
    end
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_fill();
    t_write_hit();
    t_write_miss();
    t_evict_dirty();
    t_evict_clean();
    t_index();
    t_wb_order();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule